// File: doc/BRIEF.md
# Bfloat16 to Single-Precision Widener

This block turns a 16-bit brain-float pattern into the matching 32-bit IEEE-754 single-precision pattern. Both formats have an 8-bit exponent with bias 127, so the widening is exact. The sign and the exponent carry over unchanged, and the 7 fraction bits become the top of the 23-bit fraction, with zeros below them. Alongside the result the block reports the class of the value on five one-hot flags: zero, subnormal, normal, infinity or NaN.

A word can be presented in parallel with a valid strobe. It can also be shifted in one bit per qualified cycle, most significant bit first, through a 16-step deserializer. The serial path can be removed by a parameter. Every result is registered and marked by a one-cycle `out_valid` pulse. The result word and the flags hold their values until the next result.

Top module: `bf16_widen`

## Requirements
- R1: For an input `b`, the result is `out_word[31]=b[15]`, `out_word[30:23]=b[14:7]`, `out_word[22:16]=b[6:0]` and `out_word[15:0]=0`. For example, 0x3F80 gives 0x3F800000 and 0xBF80 gives 0xBF800000.
- R2: An exponent field of 0xFF with a zero fraction gives `is_inf`, and the result is 0x7F800000 or 0xFF800000 depending on the input sign.
- R3: An exponent field of 0xFF with a nonzero fraction gives `is_nan`. The result keeps the sign, has the exponent 0xFF, and has a nonzero `out_word[22:16]` equal to the input fraction.
- R4: An exponent field of 0 with a zero fraction gives `is_zero`, and the result is 0x00000000 or 0x80000000 depending on the sign.
- R5: An exponent field of 0 with a nonzero fraction gives `is_sub`, and the result keeps exponent 0. For example, 0x000F gives 0x000F0000.
- R6: Any other exponent field (1 to 0xFE) gives `is_norm`.
- R7: The flags are ordered {is_zero,is_sub,is_norm,is_inf,is_nan}. Exactly one flag is high whenever `out_valid` is high, and no flag is ever high together with another.
- R8: When `in_valid` is high at a clock edge, `out_valid` is high for exactly the next cycle and carries the conversion of `in_word`.
- R9: With the serial path enabled, each edge that has `ser_valid` high shifts `ser_bit` in, most significant bit first. Cycles with `ser_valid` low add no bit. After the sixteenth bit, `out_valid` rises one cycle after the cycle in which that bit was captured.
- R10: If `in_valid` is high in the cycle in which a serial word becomes ready, the parallel word is converted. The serial word is dropped and is never output.
- R11: While `rst` is high and after it falls, `out_valid`, `out_word` and all flags are 0, and the serial bit count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Parallel word strobe |
| in_word | input | 16 | Parallel bfloat16 word |
| ser_valid | input | 1 | Serial bit qualifier |
| ser_bit | input | 1 | Serial data, MSB first |
| out_valid | output | 1 | One-cycle result strobe |
| out_word | output | 32 | Single-precision result |
| is_zero | output | 1 | Class: signed zero |
| is_sub | output | 1 | Class: subnormal |
| is_norm | output | 1 | Class: normal |
| is_inf | output | 1 | Class: infinity |
| is_nan | output | 1 | Class: NaN |

## Verification
A parallel strobe and the completion of a serial word can fall in the same cycle, and the two compete for the single output register. The bench shifts in fifteen bits and then the sixteenth. It raises `in_valid` in the exact cycle the deserializer reports a full word. It then checks that the output carries the parallel conversion, and that no second pulse carrying the serial word follows in the next cycle.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  localparam int BF_W      = 16;
  localparam int EXP_W     = 8;
  localparam int SP_W      = 32;
  localparam int CLS_N     = 5;
  // one-hot class positions, MSB..LSB = zero, sub, norm, inf, nan
  localparam int CLS_ZERO  = 4;
  localparam int CLS_SUB   = 3;
  localparam int CLS_NORM  = 2;
  localparam int CLS_INF   = 1;
  localparam int CLS_NAN   = 0;
endpackage

// File: rtl/bfw_deser.sv
module bfw_deser #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              word_rdy,
  output logic [WORD_W-1:0] word_out
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic              rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      if (bit_vld) begin
        shreg_q <= {shreg_q[WORD_W-2:0], bit_in};
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          rdy_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_rdy = rdy_q;
  assign word_out = shreg_q;
endmodule

// File: rtl/bfw_unpack.sv
module bfw_unpack
  import bfw_pkg::*;
#(
  parameter int IN_W  = BF_W,
  parameter int EW    = EXP_W,
  parameter int OUT_W = SP_W
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] wide,
  output logic [CLS_N-1:0] cls
);
  localparam int FW     = IN_W - 1 - EW;
  localparam int OUT_FW = OUT_W - 1 - EW;
  localparam int PAD_W  = OUT_FW - FW;

  logic          sgn;
  logic [EW-1:0] expf;
  logic [FW-1:0] frac;
  logic          exp_max, exp_min, frac_nz;

  always_comb begin
    sgn     = raw[IN_W-1];
    expf    = raw[IN_W-2 -: EW];
    frac    = raw[FW-1:0];
    exp_max = &expf;
    exp_min = ~|expf;
    frac_nz = |frac;

    // fields carry over verbatim; low fraction bits are padded with zeros
    wide = {sgn, expf, frac, {PAD_W{1'b0}}};

    cls = '0;
    if (exp_max)      cls[frac_nz ? CLS_NAN : CLS_INF]  = 1'b1;
    else if (exp_min) cls[frac_nz ? CLS_SUB : CLS_ZERO] = 1'b1;
    else              cls[CLS_NORM]                     = 1'b1;
  end
endmodule

// File: rtl/bf16_widen.sv
module bf16_widen
  import bfw_pkg::*;
#(
  parameter int IN_W      = BF_W,
  parameter int EW        = EXP_W,
  parameter int OUT_W     = SP_W,
  parameter bit SERIAL_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_word,
  input  logic             ser_valid,
  input  logic             ser_bit,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word,
  output logic             is_zero,
  output logic             is_sub,
  output logic             is_norm,
  output logic             is_inf,
  output logic             is_nan
);
  logic              ser_rdy;
  logic [IN_W-1:0]   ser_word;
  logic [IN_W-1:0]   src;
  logic [OUT_W-1:0]  wide;
  logic [CLS_N-1:0]  cls;
  logic              load;
  logic [OUT_W-1:0]  word_q;
  logic [CLS_N-1:0]  cls_q;
  logic              vld_q;

  generate
    if (SERIAL_EN) begin : g_ser
      bfw_deser #(.WORD_W(IN_W)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .bit_vld  (ser_valid),
        .bit_in   (ser_bit),
        .word_rdy (ser_rdy),
        .word_out (ser_word)
      );
    end else begin : g_noser
      assign ser_rdy  = 1'b0;
      assign ser_word = '0;
    end
  endgenerate

  // parallel strobe wins a same-cycle collision; the serial word is dropped
  assign src  = in_valid ? in_word : ser_word;
  assign load = in_valid | ser_rdy;

  bfw_unpack #(.IN_W(IN_W), .EW(EW), .OUT_W(OUT_W)) u_unpack (
    .raw  (src),
    .wide (wide),
    .cls  (cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      word_q <= '0;
      cls_q  <= '0;
    end else begin
      vld_q <= load;
      if (load) begin
        word_q <= wide;
        cls_q  <= cls;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;
  assign is_zero   = cls_q[CLS_ZERO];
  assign is_sub    = cls_q[CLS_SUB];
  assign is_norm   = cls_q[CLS_NORM];
  assign is_inf    = cls_q[CLS_INF];
  assign is_nan    = cls_q[CLS_NAN];
endmodule

// File: rtl/bf16_widen_chk.sv
module bf16_widen_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_word,
  input logic             ser_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_word,
  input logic             is_zero,
  input logic             is_sub,
  input logic             is_norm,
  input logic             is_inf,
  input logic             is_nan
);
  localparam int CW = $clog2(IN_W);
  logic [CW-1:0] bits_q;
  logic          full_q;

  // independent count of captured serial bits
  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= ser_valid && (bits_q == CW'(IN_W - 1));
      if (ser_valid) bits_q <= bits_q + 1'b1;
    end
  end

  // R8
  par_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  par_fields_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word[OUT_W-1 -: IN_W] == $past(in_word)) &&
                 (out_word[OUT_W-IN_W-1:0] == '0));

  // R7
  class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_zero, is_sub, is_norm, is_inf, is_nan}) &&
    (out_valid -> $countones({is_zero, is_sub, is_norm, is_inf, is_nan}) == 1));

  // R2
  inf_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && is_inf) |-> out_word[30:0] == 31'h7F800000);

  // R3
  nan_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && is_nan) |-> (out_word[30:23] == 8'hFF) && (out_word[22:16] != 7'd0));

  // R4
  zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && is_zero) |-> out_word[30:0] == 31'd0);

  // R9
  src_origin_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) || $past(full_q)));

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && out_word == '0);
endmodule

bind bf16_widen bf16_widen_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .ser_valid (ser_valid),
  .out_valid (out_valid),
  .out_word  (out_word),
  .is_zero   (is_zero),
  .is_sub    (is_sub),
  .is_norm   (is_norm),
  .is_inf    (is_inf),
  .is_nan    (is_nan)
);

// File: tb/bf16_widen_test.sv
`timescale 1ns/1ps
module bf16_widen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        ser_valid = 1'b0;
  logic        ser_bit = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        is_zero, is_sub, is_norm, is_inf, is_nan;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bf16_widen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .out_valid(out_valid),
    .out_word(out_word), .is_zero(is_zero), .is_sub(is_sub),
    .is_norm(is_norm), .is_inf(is_inf), .is_nan(is_nan)
  );

  function automatic logic [31:0] exp_word(input logic [15:0] b);
    return {b[15], b[14:7], b[6:0], 16'h0000};
  endfunction

  // {zero, sub, norm, inf, nan}
  function automatic logic [4:0] exp_cls(input logic [15:0] b);
    logic [7:0] e = b[14:7];
    logic [6:0] f = b[6:0];
    if (e == 8'hFF) return (f != 0) ? 5'b00001 : 5'b00010;
    if (e == 8'h00) return (f != 0) ? 5'b01000 : 5'b10000;
    return 5'b00100;
  endfunction

  function automatic string req_of(input logic [15:0] b);
    case (exp_cls(b))
      5'b00010: return "R2";
      5'b00001: return "R3";
      5'b10000: return "R4";
      5'b01000: return "R5";
      default:  return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [15:0] b);
    check(req, {31'd0, out_valid}, 64'd1);
    check(req, {32'd0, out_word}, {32'd0, exp_word(b)});
    check({req, "/R7"}, {59'd0, is_zero, is_sub, is_norm, is_inf, is_nan}, {59'd0, exp_cls(b)});
  endtask

  // drive in one cycle, result visible at the following negedge (R8)
  task automatic send_par(input logic [15:0] b, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(req, b);
  endtask

  task automatic shift_bits(input logic [15:0] b, input int nbits, input bit gaps);
    for (int i = 15; i > 15 - nbits; i--) begin
      @(negedge clk);
      if (gaps && (i % 3 == 0)) begin
        ser_valid = 1'b0;
        ser_bit   = ~b[i];
        @(negedge clk);
      end
      ser_valid = 1'b1;
      ser_bit   = b[i];
    end
  endtask

  // R9: the last bit is captured at edge k; result appears after edge k+1
  task automatic send_ser(input logic [15:0] b, input bit gaps);
    shift_bits(b, 16, gaps);
    @(negedge clk);
    ser_valid = 1'b0;
    check("R9 early", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check_result("R9", b);
  endtask

  initial begin
    logic [15:0] w;
    void'($urandom(32'h5EED_0B16));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {27'd0, out_valid, is_zero, is_sub, is_norm, is_inf, is_nan}, 64'd0);
    check("R11", {32'd0, out_word}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0);

    // directed corners
    send_par(16'h3F80, "R1");
    check("R6", {32'd0, out_word}, 64'h3F800000);
    send_par(16'hBF80, "R1");
    check("R6", {32'd0, out_word}, 64'hBF800000);
    send_par(16'h000F, "R5");
    check("R5", {32'd0, out_word}, 64'h000F0000);
    send_par(16'h7F80, "R2");
    check("R2", {32'd0, out_word}, 64'h7F800000);
    send_par(16'hFF80, "R2");
    check("R2", {32'd0, out_word}, 64'hFF800000);
    send_par(16'h7F81, "R3");
    check("R3", {57'd0, out_word[22:16]}, 64'h01);
    send_par(16'hFFC0, "R3");
    send_par(16'h0000, "R4");
    send_par(16'h8000, "R4");
    check("R4", {32'd0, out_word}, 64'h80000000);
    send_par(16'h807F, "R5");
    send_par(16'h0080, "R6");
    send_par(16'h7F7F, "R6");

    // R8: one-cycle pulse, result held afterwards
    @(negedge clk);
    check("R8", {63'd0, out_valid}, 64'd0);
    check("R8 hold", {32'd0, out_word}, {32'd0, exp_word(16'h7F7F)});

    // back-to-back parallel words
    @(negedge clk); in_valid = 1'b1; in_word = 16'h4049;
    @(negedge clk); check_result("R8", 16'h4049); in_word = 16'hC2F7;
    @(negedge clk); check_result("R8", 16'hC2F7); in_valid = 1'b0;

    // random parallel
    for (int n = 0; n < 300; n++) begin
      w = 16'($urandom);
      send_par(w, req_of(w));
    end

    // serial, directed and random, with and without gaps
    send_ser(16'h3F80, 1'b0);
    send_ser(16'h000F, 1'b1);
    send_ser(16'hFF81, 1'b0);
    for (int n = 0; n < 20; n++) begin
      w = 16'($urandom);
      send_ser(w, n[0]);
    end

    // R10: parallel strobe in the cycle the serial word becomes ready
    shift_bits(16'h1234, 16, 1'b0);
    @(negedge clk);
    ser_valid = 1'b0;
    in_valid  = 1'b1;
    in_word   = 16'hC0A0;
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R10", 16'hC0A0);
    @(negedge clk);
    check("R10 dropped", {63'd0, out_valid}, 64'd0);
    check("R10 dropped", {32'd0, out_word}, {32'd0, exp_word(16'hC0A0)});
    // deserializer restarts cleanly after the drop
    send_ser(16'h0001, 1'b0);

    // R11: reset mid-word clears the bit count
    shift_bits(16'hFFFF, 7, 1'b0);
    @(negedge clk);
    ser_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", {31'd0, out_valid, out_word}, 64'd0);
    send_ser(16'h4000, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule